// File: doc/BRIEF.md
# Relative-Threshold FSK Demodulator with Start Detection

This block recovers data from a two-tone transponder reply that arrives as a square wave from a limiter. It measures each input period by counting reference clocks between consecutive rising edges. When the read phase begins, it averages the first few periods to learn the low-bit (resonance) period. It then sets a decision threshold a fixed number of counts above that period. Because the threshold follows the measured tone, the decision depends on the shift between the two tones and not on their absolute values.

Each later period is classified as short (low bit) or long (high bit), with a hysteresis band around the threshold. A two-period filter smooths the result, and the filtered stream enters a 12-entry history that looks for the start pattern. Once the start is seen, the filtered classes are grouped into windows. A majority vote decides each bit, and bits are packed least significant first into bytes that appear with a one-cycle strobe. Dropping the read-phase enable returns everything to its idle state.

Top module: `fsk_demod`

## Requirements
- R1: A period is the number of clock cycles between two consecutive rising edges of `lim_in`. The first rising edge after `rd_en` goes high only arms the measurement and reports no period.
- R2: The first 4 periods reported after `rd_en` rises are summed, and the sum is shifted right by 2 (truncating) to give the calibration count. None of these 4 periods is classified.
- R3: The threshold is the calibration count plus THR_OFS (default 6). A period of at least threshold+HYS (HYS default 1) is high class (1), and a period of at most threshold−HYS is low class (0). A period strictly inside the band keeps the previous class. The class is 0 when calibration completes.
- R4: The filtered class takes the new raw class only when it equals the raw class of the period before. Otherwise the filtered class is unchanged, so one isolated deviating period is removed.
- R5: Filtered classes are shifted into a 12-entry history that is all high-class when `rd_en` rises. `start_detected` goes high once the history holds 8 low-class entries followed by 4 high-class entries (newest last). It then stays high while `rd_en` stays high.
- R6: After the start, each run of BIT_PER filtered classes forms one data bit, which is 1 when more than BIT_PER/2 of the classes are high. The period that completes the start pattern is not part of any bit.
- R7: Every 8 data bits form one byte, with the first bit received placed in bit 0. `byte_valid` is high for exactly one cycle per byte, and `data_byte` changes only in that cycle.
- R8: When `rd_en` is low, the calibration, the history, the start flag and any partly assembled byte are cleared. `start_detected` is low from the second cycle after `rd_en` falls, and no byte is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read-phase enable; low clears all session state |
| lim_in | input | 1 | Limiter output carrying the frequency-coded signal |
| start_detected | output | 1 | High once the start pattern has been seen in this session |
| data_byte | output | BYTE_W | Last assembled byte, first bit in bit 0 |
| byte_valid | output | 1 | One-cycle strobe marking a new `data_byte` |

## Verification
The bench builds the block with an 8-bit period counter, a 5-period bit window, a threshold offset of 6 and a hysteresis of 1. Tone periods of roughly 40 to 75 clocks then give whole bytes within a few thousand cycles. The odd window makes every majority decision strict, even when the one-period filter lag falls at a bit transition. The small hysteresis lets the bench place periods exactly on the threshold and exactly on both band edges, which exercises the hold behaviour of the classifier. Short sessions also make the exact 7-low-period boundary for start detection, the rejected 6-period case and the mid-byte abort cheap to reach.

// File: rtl/fskd_pkg.sv
package fskd_pkg;
  // width of a counter that must hold values 0..n-1, never below one bit
  function automatic int cnt_w(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fskd_period_meter.sv
module fskd_period_meter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             lim_in,
  output logic [CNT_W-1:0] per_val,
  output logic             per_vld
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             lim_q, lim_qq, armed;
  logic [CNT_W-1:0] cnt;
  logic             rise;

  assign rise = lim_q & ~lim_qq;

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q   <= 1'b0;
      lim_qq  <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
      per_val <= '0;
      per_vld <= 1'b0;
    end else begin
      lim_q   <= lim_in;
      lim_qq  <= lim_q;
      per_vld <= 1'b0;
      if (!en) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (rise) begin
        armed   <= 1'b1;
        cnt     <= CNT_W'(1);
        per_vld <= armed;
        per_val <= cnt;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8: a disabled meter reports nothing
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !per_vld);
  // R1: a reported period is never empty
  assert_per_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
    per_vld |-> per_val != '0);
endmodule

// File: rtl/fskd_classifier.sv
module fskd_classifier #(
  parameter int CNT_W    = 10,
  parameter int CAL_LOG2 = 2,
  parameter int THR_OFS  = 6,
  parameter int HYS      = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] per_val,
  input  logic             per_vld,
  output logic             cls_bit,
  output logic             cls_vld
);
  import fskd_pkg::*;
  localparam int CAL_N = 1 << CAL_LOG2;
  localparam int ACC_W = CNT_W + CAL_LOG2;
  localparam int TW    = ACC_W + 2;
  localparam int CW    = cnt_w(CAL_N);

  logic [ACC_W-1:0] acc, acc_n;
  logic [CW-1:0]    cal_cnt;
  logic [TW-1:0]    thr, per_x;
  logic             cal_done, is_hi, is_lo;

  assign acc_n = acc + ACC_W'(per_val);
  assign per_x = TW'(per_val);
  assign is_hi = per_x >= thr + TW'(HYS);
  assign is_lo = per_x + TW'(HYS) <= thr;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      acc      <= '0;
      cal_cnt  <= '0;
      thr      <= '0;
      cal_done <= 1'b0;
      cls_bit  <= 1'b0;
      cls_vld  <= 1'b0;
    end else begin
      cls_vld <= 1'b0;
      if (per_vld) begin
        if (!cal_done) begin
          acc <= acc_n;
          if (cal_cnt == CW'(CAL_N - 1)) begin
            thr      <= TW'(acc_n >> CAL_LOG2) + TW'(THR_OFS);
            cal_done <= 1'b1;
          end else begin
            cal_cnt <= cal_cnt + 1'b1;
          end
        end else begin
          cls_vld <= 1'b1;
          if (is_hi)      cls_bit <= 1'b1;
          else if (is_lo) cls_bit <= 1'b0;
        end
      end
    end
  end

  // R2: nothing is classified while calibrating
  assert_quiet_in_cal_R2: assert property (@(posedge clk) disable iff (rst)
    !cal_done |=> !cls_vld);
  // R3: a period inside the band keeps the class
  assert_band_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (en && cal_done && per_vld && !is_hi && !is_lo) |=> (cls_vld && cls_bit == $past(cls_bit)));
endmodule

// File: rtl/fskd_start_detect.sv
module fskd_start_detect #(
  parameter int SR_W = 12,
  parameter int LEAD = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cls_vld,
  input  logic cls_bit,
  output logic start_q,
  output logic dat_vld,
  output logic dat_bit
);
  localparam int TRAIL = SR_W - LEAD;
  localparam logic [SR_W-1:0] PATTERN = {{LEAD{1'b0}}, {TRAIL{1'b1}}};

  logic            raw_prev, filt, filt_n;
  logic [SR_W-1:0] hist, hist_n;

  assign filt_n = (cls_bit == raw_prev) ? cls_bit : filt;
  assign hist_n = {hist[SR_W-2:0], filt_n};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      raw_prev <= 1'b0;
      filt     <= 1'b0;
      hist     <= '1;
      start_q  <= 1'b0;
      dat_vld  <= 1'b0;
      dat_bit  <= 1'b0;
    end else begin
      dat_vld <= 1'b0;
      if (cls_vld) begin
        raw_prev <= cls_bit;
        filt     <= filt_n;
        hist     <= hist_n;
        dat_vld  <= start_q;
        dat_bit  <= filt_n;
        if (hist_n == PATTERN) start_q <= 1'b1;
      end
    end
  end

  // R5: the start flag holds while enabled
  assert_start_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (start_q && en) |=> start_q);
  // R6: data periods only flow after the start
  assert_data_after_start_R6: assert property (@(posedge clk) disable iff (rst)
    dat_vld |-> start_q);
endmodule

// File: rtl/fskd_byte_asm.sv
module fskd_byte_asm #(
  parameter int BIT_PER = 16,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              dat_vld,
  input  logic              dat_bit,
  output logic [BYTE_W-1:0] data_byte,
  output logic              byte_valid
);
  import fskd_pkg::*;
  localparam int PW = cnt_w(BIT_PER);
  localparam int OW = $clog2(BIT_PER + 1);
  localparam int BW = cnt_w(BYTE_W);

  logic [PW-1:0]     per_cnt;
  logic [OW-1:0]     ones, ones_n;
  logic [BW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] sh, sh_n;
  logic              maj;

  assign ones_n = ones + OW'(dat_bit);
  assign maj    = ones_n > OW'(BIT_PER / 2);
  assign sh_n   = {maj, sh[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      data_byte <= '0;
    end else if (en && dat_vld && per_cnt == PW'(BIT_PER - 1) && bit_cnt == BW'(BYTE_W - 1)) begin
      data_byte <= sh_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      per_cnt    <= '0;
      ones       <= '0;
      bit_cnt    <= '0;
      sh         <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (dat_vld) begin
        if (per_cnt == PW'(BIT_PER - 1)) begin
          per_cnt <= '0;
          ones    <= '0;
          sh      <= sh_n;
          if (bit_cnt == BW'(BYTE_W - 1)) begin
            bit_cnt    <= '0;
            byte_valid <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end else begin
          per_cnt <= per_cnt + 1'b1;
          ones    <= ones_n;
        end
      end
    end
  end

  // R7: the strobe lasts one cycle
  assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);
  // R7: the byte only moves with its strobe
  assert_byte_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !byte_valid |-> $stable(data_byte));
endmodule

// File: rtl/fsk_demod.sv
module fsk_demod #(
  parameter int CNT_W    = 10,
  parameter int CAL_LOG2 = 2,
  parameter int THR_OFS  = 6,
  parameter int HYS      = 1,
  parameter int SR_W     = 12,
  parameter int LEAD     = 8,
  parameter int BIT_PER  = 16,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              lim_in,
  output logic              start_detected,
  output logic [BYTE_W-1:0] data_byte,
  output logic              byte_valid
);
  logic [CNT_W-1:0] per_val;
  logic             per_vld, cls_bit, cls_vld, dat_vld, dat_bit;

  fskd_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst(rst), .en(rd_en), .lim_in(lim_in),
    .per_val(per_val), .per_vld(per_vld)
  );

  fskd_classifier #(.CNT_W(CNT_W), .CAL_LOG2(CAL_LOG2), .THR_OFS(THR_OFS), .HYS(HYS)) u_cls (
    .clk(clk), .rst(rst), .en(rd_en), .per_val(per_val), .per_vld(per_vld),
    .cls_bit(cls_bit), .cls_vld(cls_vld)
  );

  fskd_start_detect #(.SR_W(SR_W), .LEAD(LEAD)) u_start (
    .clk(clk), .rst(rst), .en(rd_en), .cls_vld(cls_vld), .cls_bit(cls_bit),
    .start_q(start_detected), .dat_vld(dat_vld), .dat_bit(dat_bit)
  );

  fskd_byte_asm #(.BIT_PER(BIT_PER), .BYTE_W(BYTE_W)) u_asm (
    .clk(clk), .rst(rst), .en(rd_en), .dat_vld(dat_vld), .dat_bit(dat_bit),
    .data_byte(data_byte), .byte_valid(byte_valid)
  );

  // R8: leaving the read phase drops the start flag
  assert_clear_on_exit_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !start_detected);
endmodule

// File: tb/tb_fsk_demod.sv
module tb_fsk_demod;
  localparam int CNT_W   = 8;
  localparam int BIT_PER = 5;
  localparam int THR_OFS = 6;
  localparam int HYS     = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_en = 1'b0;
  logic       lim_in = 1'b0;
  logic       start_detected;
  logic [7:0] data_byte;
  logic       byte_valid;

  int n_cmp = 0;
  int n_bad = 0;
  int n_got = 0;
  logic [7:0] got [0:63];

  always #2 clk = ~clk;

  fsk_demod #(.CNT_W(CNT_W), .THR_OFS(THR_OFS), .HYS(HYS), .BIT_PER(BIT_PER)) dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .lim_in(lim_in),
    .start_detected(start_detected), .data_byte(data_byte), .byte_valid(byte_valid)
  );

  always @(negedge clk) begin
    if (byte_valid && n_got < 64) begin
      got[n_got] = data_byte;
      n_got++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int thr_of(input int a, input int b, input int c, input int d);
    return ((a + b + c + d) >> 2) + THR_OFS;
  endfunction

  task automatic send_per(input int p);
    lim_in = 1'b1;
    repeat (p / 2) @(negedge clk);
    lim_in = 1'b0;
    repeat (p - p / 2) @(negedge clk);
  endtask

  // noise: 0 none, 1 opposite-class period, 2 period exactly on the threshold
  task automatic session(input int base, input int lo_gap, input int hi_gap, input int n_low,
                         input bit glitch, input int noise, input int nbytes,
                         input bit expect_start, input bit abort);
    int c0, c1, c2, c3, thr, lo, hi, p;
    logic [7:0] b [0:7];
    bit prev, bt;
    rd_en = 1'b1;
    n_got = 0;
    c0 = base + int'($urandom_range(0, 3));
    c1 = base + int'($urandom_range(0, 3));
    c2 = base + int'($urandom_range(0, 3));
    c3 = base + int'($urandom_range(0, 3));
    send_per(c0); send_per(c1); send_per(c2); send_per(c3);
    thr = thr_of(c0, c1, c2, c3);
    lo = thr - HYS - lo_gap;
    hi = thr + HYS + hi_gap;
    for (int i = 0; i < n_low; i++) send_per(lo);
    chk("R5 no start before pattern", int'(start_detected), 0);
    if (glitch) begin
      send_per(hi);
      send_per(lo);
    end
    repeat (5) send_per(hi);
    if (abort) begin
      repeat (3 * BIT_PER) send_per(lo);
      rd_en = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 start cleared after abort", int'(start_detected), 0);
      chk("R8 partial byte not reported", n_got, 0);
      return;
    end
    if (!expect_start) begin
      repeat (8) send_per(hi);
    end
    prev = 1'b1;
    for (int k = 0; k < nbytes; k++) begin
      b[k] = 8'($urandom);
      for (int j = 0; j < 8; j++) begin
        bt = b[k][j];
        for (int m = 0; m < BIT_PER; m++) begin
          p = bt ? hi : lo;
          if (noise != 0 && m == 2 && bt == prev) p = (noise == 1) ? (bt ? lo : hi) : thr;
          send_per(p);
        end
        prev = bt;
      end
    end
    send_per(lo);
    repeat (12) @(negedge clk);
    chk("R5 start flag at end of session", int'(start_detected), int'(expect_start));
    chk("R7 byte count", n_got, expect_start ? nbytes : 0);
    if (expect_start) begin
      for (int k = 0; k < nbytes && k < n_got; k++)
        chk("R1 R2 R3 R4 R6 R7 byte value", int'(got[k]), int'(b[k]));
    end
    rd_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 start cleared on exit", int'(start_detected), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog expired: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R5 reset start flag", int'(start_detected), 0);
    chk("R7 reset strobe", int'(byte_valid), 0);
    chk("R7 reset byte", int'(data_byte), 0);
    // R3 R2: periods exactly on both band edges of an averaged threshold
    session(50, 0, 0, 10, 1'b0, 0, 2, 1'b1, 1'b0);
    // R5: exactly seven raw lows plus filter lag reach the start; R4 glitch removal
    session(45, 3, 4, 7, 1'b0, 1, 2, 1'b1, 1'b0);
    // R4 non-monotonic transition; R3 periods on the threshold keep the class
    session(55, 2, 2, 9, 1'b1, 2, 2, 1'b1, 1'b0);
    // R5: six raw lows are one short of the pattern
    session(48, 1, 1, 6, 1'b0, 0, 0, 1'b0, 1'b0);
    // R8: abort mid-byte, then a clean session must not see leftovers
    session(52, 2, 3, 10, 1'b0, 0, 0, 1'b1, 1'b1);
    session(52, 2, 3, 10, 1'b0, 0, 1, 1'b1, 1'b0);
    for (int s = 0; s < 5; s++) begin
      session(int'($urandom_range(40, 60)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
              int'($urandom_range(8, 12)), 1'($urandom_range(0, 1)), int'($urandom_range(0, 2)),
              2, 1'b1, 1'b0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule